// File: doc/BRIEF.md
# ADC round-robin sample sequencer

This block is the digital controller that sits around a multi-channel sampling converter. It picks the input to convert, starts conversions one at a time or free-running at a paced rate, and walks through a programmable set of channels in a fixed rotation. Finished results go into a small show-ahead sample FIFO. The FIFO raises a DMA request once its fill level reaches a programmed threshold.

There are five channels, 0 to 4. Channel 4 is the on-die temperature sensor. Free-running conversions are paced by an integer divider plus a 1/256 fractional part, and no interval is shorter than 96 cycles. The analog converter is replaced by a behavioural model. The model captures the selected input word when a conversion starts and returns it after a fixed latency. Software drains results by popping the FIFO. An overflow is recorded in a sticky flag that is cleared by writing 1 to it.

Top module: `adc_rr_sequencer`

## Requirements
- R1: After reset, `ready` is 1, `fifo_empty` is 1, `fifo_level` is 0, `dreq` is 0 and `fifo_ovf` is 0.
- R2: While `start_many` is low and `ready` is high, a one-cycle `start_once` starts one conversion of `start_chan`. `ready` reads 0 from the cycle after the start until the conversion completes. The result, the input word of that channel, enters the FIFO CONV_LAT cycles after the start.
- R3: On a rising edge of `start_many`, the first conversion uses `start_chan`. Each later channel is the lowest set bit of `rr_mask` strictly above the previous channel. When no set bit lies above it, the next channel wraps to the lowest set bit of `rr_mask`. Bit i of `rr_mask` stands for channel i.
- R4: With `rr_mask` equal to 0, free-running mode converts `start_chan` on every slot.
- R5: Channel 4 is converted only while `temp_en` is 1. If channel 4 falls on a slot while `temp_en` is 0, no conversion starts: `ready` stays 1 and no sample is pushed. The rotation still moves past channel 4.
- R6: With `div_int` equal to 0, free-running conversions start exactly 96 cycles apart.
- R7: With `div_int` nonzero, the interval is 1+`div_int` cycles plus `div_frac`/256 of a cycle. The fraction is accumulated from 0 at each rising edge of `start_many`, so any 8 consecutive intervals total 8·(1+`div_int`)+⌊8·`div_frac`/256⌋ cycles when 8·`div_frac` is a multiple of 256. A `div_int` from 1 to 95 is treated as 96.
- R8: With `fifo_shift` set, a sample is stored as its 12-bit result shifted right by 4. The stored value holds the top 8 bits in bits 7:0, and bits 11:8 are 0.
- R9: `dreq` is 1 exactly when `dreq_en` is 1 and `fifo_level` is at least `fifo_thresh`.
- R10: The FIFO returns samples in conversion order on `fifo_data`, and a one-cycle `fifo_rd` removes the head entry. `fifo_empty` is 1 when `fifo_level` is 0, and `fifo_level` never exceeds 4.
- R11: A sample that completes while the FIFO holds 4 entries is dropped and `fifo_ovf` becomes 1. `fifo_ovf` stays 1 until `ovf_clr` is pulsed.
- R12: While `fifo_en` is 0, completed samples are not stored and `fifo_level` does not rise.
- R13: After `start_many` is cleared, no further free-running conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_chan | input | 3 | Starting channel select |
| rr_mask | input | 5 | Rotation channel mask, bit i is channel i |
| start_once | input | 1 | One-cycle request for a single conversion |
| start_many | input | 1 | Free-running conversions while high |
| temp_en | input | 1 | Temperature sensor (channel 4) enable |
| div_int | input | 16 | Divider integer part |
| div_frac | input | 8 | Divider fraction in 1/256 cycle |
| fifo_en | input | 1 | Store completed samples in the FIFO |
| dreq_en | input | 1 | Allow the DMA request |
| fifo_thresh | input | 3 | Fill level that raises the DMA request |
| fifo_shift | input | 1 | Store only the top 8 result bits |
| ovf_clr | input | 1 | Write-one pulse clearing the overflow flag |
| fifo_rd | input | 1 | Pop the FIFO head |
| ain | input | 60 | Converter input words, 12 bits per channel, channel 0 in the low bits |
| ready | output | 1 | Converter idle |
| fifo_data | output | 12 | FIFO head sample |
| fifo_level | output | 3 | FIFO fill level |
| fifo_empty | output | 1 | FIFO empty |
| fifo_ovf | output | 1 | Sticky overflow flag |
| dreq | output | 1 | DMA request |

## Verification
On every cycle, the assertions check the FIFO level bound, the stickiness of the overflow flag, the drop-on-full behaviour, the rule that no sample is stored while filling is disabled, the repeat of the starting channel under an empty mask, and the fall of `ready` after each start. Only the bench scenarios can show the rotation order across wrap points, skipping the sensor channel, the exact pacing intervals including the fractional carry, the shifted sample format, the threshold behaviour of the request, and that no conversion follows a stop. The scoreboard compares every popped sample with the channel and value predicted from the requirements and records the arrival cycle of each sample for the pacing checks.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int unsigned SEQ_NUM_CH     = 5;
   localparam int unsigned SEQ_RES_W      = 12;
   localparam int unsigned SEQ_MIN_PERIOD = 96;
   localparam int unsigned SEQ_SHIFT_BITS = 4;

   function automatic int unsigned chan_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/adc_rr_next.sv
module adc_rr_next #(
   parameter int unsigned NUM_CH = 5,
   localparam int unsigned CH_W  = adc_seq_pkg::chan_bits(NUM_CH)
) (
   input  logic [CH_W-1:0]   cur,
   input  logic [NUM_CH-1:0] mask,
   output logic [CH_W-1:0]   nxt
);
   logic found_up;
   logic found_low;
   logic [CH_W-1:0] up_ch;
   logic [CH_W-1:0] low_ch;

   always_comb begin
      found_up  = 1'b0;
      found_low = 1'b0;
      up_ch     = cur;
      low_ch    = cur;
      for (int i = 0; i < int'(NUM_CH); i++) begin
         if (!found_up && mask[i] && (i > int'(cur))) begin
            found_up = 1'b1;
            up_ch    = CH_W'(i);
         end
         if (!found_low && mask[i]) begin
            found_low = 1'b1;
            low_ch    = CH_W'(i);
         end
      end
      if (found_up)       nxt = up_ch;
      else if (found_low) nxt = low_ch;
      else                nxt = cur;
   end
endmodule

// File: rtl/adc_pacer.sv
module adc_pacer #(
   parameter int unsigned INT_W      = 16,
   parameter int unsigned FRAC_W     = 8,
   parameter int unsigned MIN_PERIOD = 96,
   localparam int unsigned CNT_W     = INT_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              rise,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              fire
);
   logic [CNT_W-1:0]  cnt;
   logic [FRAC_W-1:0] acc;
   logic [FRAC_W:0]   sum;
   logic [CNT_W-1:0]  base;
   logic [CNT_W-1:0]  period;
   logic [INT_W-1:0]  eff_int;

   assign fire    = run && (rise || (cnt == '0));
   assign sum     = {1'b0, (rise ? {FRAC_W{1'b0}} : acc)} + {1'b0, div_frac};
   assign eff_int = (div_int < INT_W'(MIN_PERIOD)) ? INT_W'(MIN_PERIOD) : div_int;
   assign base    = (div_int == '0) ? CNT_W'(MIN_PERIOD) : (CNT_W'(eff_int) + CNT_W'(1));
   assign period  = (div_int == '0) ? base : (base + CNT_W'(sum[FRAC_W]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         acc <= '0;
      end else if (!run) begin
         cnt <= '0;
         acc <= '0;
      end else if (fire) begin
         cnt <= period - CNT_W'(1);
         acc <= sum[FRAC_W-1:0];
      end else begin
         cnt <= cnt - CNT_W'(1);
      end
   end
endmodule

// File: rtl/adc_conv_model.sv
module adc_conv_model #(
   parameter int unsigned NUM_CH = 5,
   parameter int unsigned RES_W  = 12,
   parameter int unsigned LAT    = 8,
   localparam int unsigned CH_W  = adc_seq_pkg::chan_bits(NUM_CH),
   localparam int unsigned LAT_W = $clog2(LAT + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    launch,
   input  logic [CH_W-1:0]         chan,
   input  logic [NUM_CH*RES_W-1:0] ain,
   output logic                    busy,
   output logic                    done,
   output logic [RES_W-1:0]        result
);
   logic [LAT_W-1:0] cnt;
   logic [RES_W-1:0] pick;

   always_comb begin
      pick = '0;
      for (int i = 0; i < int'(NUM_CH); i++)
         if (int'(chan) == i) pick = ain[i*RES_W +: RES_W];
   end

   assign done = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         result <= '0;
      end else if (launch && !busy) begin
         busy   <= 1'b1;
         cnt    <= LAT_W'(LAT - 1);
         result <= pick;
      end else if (done) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt <= cnt - LAT_W'(1);
      end
   end
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
   parameter int unsigned W     = 12,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = (DEPTH <= 2) ? 1 : $clog2(DEPTH),
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   input  logic             ovf_clr,
   output logic [W-1:0]     rdata,
   output logic [LVL_W-1:0] level,
   output logic             empty,
   output logic             full,
   output logic             ovf
);
   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic             do_pop;
   logic             do_push;

   assign empty   = (level == '0);
   assign full    = (level == LVL_W'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         ovf    <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
         if (push && !do_push) ovf <= 1'b1;
         else if (ovf_clr)     ovf <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_rr_sequencer.sv
module adc_rr_sequencer #(
   parameter int unsigned NUM_CH     = adc_seq_pkg::SEQ_NUM_CH,
   parameter int unsigned RES_W      = adc_seq_pkg::SEQ_RES_W,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter int unsigned CONV_LAT   = 8,
   parameter int unsigned MIN_PERIOD = adc_seq_pkg::SEQ_MIN_PERIOD,
   parameter int unsigned INT_W      = 16,
   parameter int unsigned FRAC_W     = 8,
   parameter int unsigned SHIFT_BITS = adc_seq_pkg::SEQ_SHIFT_BITS,
   localparam int unsigned CH_W      = adc_seq_pkg::chan_bits(NUM_CH),
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1),
   localparam int unsigned TEMP_CH   = NUM_CH - 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CH_W-1:0]         start_chan,
   input  logic [NUM_CH-1:0]       rr_mask,
   input  logic                    start_once,
   input  logic                    start_many,
   input  logic                    temp_en,
   input  logic [INT_W-1:0]        div_int,
   input  logic [FRAC_W-1:0]       div_frac,
   input  logic                    fifo_en,
   input  logic                    dreq_en,
   input  logic [LVL_W-1:0]        fifo_thresh,
   input  logic                    fifo_shift,
   input  logic                    ovf_clr,
   input  logic                    fifo_rd,
   input  logic [NUM_CH*RES_W-1:0] ain,
   output logic                    ready,
   output logic [RES_W-1:0]        fifo_data,
   output logic [LVL_W-1:0]        fifo_level,
   output logic                    fifo_empty,
   output logic                    fifo_ovf,
   output logic                    dreq
);
   if (CONV_LAT < 1 || CONV_LAT >= MIN_PERIOD)
      $error("CONV_LAT must lie in 1..MIN_PERIOD-1");
   if ((FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0 || FIFO_DEPTH < 2)
      $error("FIFO_DEPTH must be a power of two of at least 2");
   if (NUM_CH < 2 || SHIFT_BITS >= RES_W)
      $error("bad channel count or shift");

   logic            many_q;
   logic            rise;
   logic            fire_many;
   logic            once_req;
   logic            slot;
   logic            allowed;
   logic            launch;
   logic [CH_W-1:0] ptr;
   logic [CH_W-1:0] sel_chan;
   logic [CH_W-1:0] ptr_next;
   logic            conv_busy;
   logic            conv_done;
   logic [RES_W-1:0] conv_res;
   logic [RES_W-1:0] push_data;
   logic            fifo_full;

   assign rise     = start_many && !many_q;
   assign once_req = start_once && !start_many;
   assign slot     = fire_many || once_req;
   assign sel_chan = (start_many && !rise) ? ptr : start_chan;
   assign allowed  = (int'(sel_chan) < int'(NUM_CH)) &&
                     !((int'(sel_chan) == int'(TEMP_CH)) && !temp_en);
   assign launch   = slot && allowed && !conv_busy;
   assign ready    = !conv_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         many_q <= 1'b0;
         ptr    <= '0;
      end else begin
         many_q <= start_many;
         if (fire_many) ptr <= ptr_next;
      end
   end

   adc_rr_next #(.NUM_CH(NUM_CH)) u_next (
      .cur  (sel_chan),
      .mask (rr_mask),
      .nxt  (ptr_next)
   );

   adc_pacer #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_PERIOD(MIN_PERIOD)) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (start_many),
      .rise     (rise),
      .div_int  (div_int),
      .div_frac (div_frac),
      .fire     (fire_many)
   );

   adc_conv_model #(.NUM_CH(NUM_CH), .RES_W(RES_W), .LAT(CONV_LAT)) u_conv (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .chan   (sel_chan),
      .ain    (ain),
      .busy   (conv_busy),
      .done   (conv_done),
      .result (conv_res)
   );

   assign push_data = fifo_shift ? (conv_res >> SHIFT_BITS) : conv_res;

   adc_sample_fifo #(.W(RES_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (conv_done && fifo_en),
      .wdata   (push_data),
      .pop     (fifo_rd),
      .ovf_clr (ovf_clr),
      .rdata   (fifo_data),
      .level   (fifo_level),
      .empty   (fifo_empty),
      .full    (fifo_full),
      .ovf     (fifo_ovf)
   );

   assign dreq = dreq_en && (fifo_level >= fifo_thresh);
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
   parameter int unsigned NUM_CH     = 5,
   parameter int unsigned FIFO_DEPTH = 4,
   localparam int unsigned CH_W      = adc_seq_pkg::chan_bits(NUM_CH),
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_many,
   input logic [CH_W-1:0]   start_chan,
   input logic [NUM_CH-1:0] rr_mask,
   input logic              launch,
   input logic [CH_W-1:0]   launch_chan,
   input logic              ready,
   input logic [LVL_W-1:0]  fifo_level,
   input logic              fifo_ovf,
   input logic              ovf_clr,
   input logic              conv_done,
   input logic              fifo_en,
   input logic              fifo_rd
);
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(FIFO_DEPTH)); // R10

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ovf && !ovf_clr |=> fifo_ovf); // R11

   AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done && fifo_en && !fifo_rd && (fifo_level == LVL_W'(FIFO_DEPTH))
      |=> fifo_ovf && (fifo_level == LVL_W'(FIFO_DEPTH))); // R11

   AST_NO_FILL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> fifo_level <= $past(fifo_level)); // R12

   AST_ZERO_MASK_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      launch && start_many && (rr_mask == '0) |-> launch_chan == start_chan); // R4

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !ready); // R2
endmodule

bind adc_rr_sequencer adc_seq_checker #(.NUM_CH(NUM_CH), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_many  (start_many),
   .start_chan  (start_chan),
   .rr_mask     (rr_mask),
   .launch      (launch),
   .launch_chan (sel_chan),
   .ready       (ready),
   .fifo_level  (fifo_level),
   .fifo_ovf    (fifo_ovf),
   .ovf_clr     (ovf_clr),
   .conv_done   (conv_done),
   .fifo_en     (fifo_en),
   .fifo_rd     (fifo_rd)
);

// File: tb/tb_adc_rr_sequencer.sv
module tb_adc_rr_sequencer;
   localparam int LAT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  start_chan = '0;
   logic [4:0]  rr_mask = '0;
   logic        start_once = 1'b0;
   logic        start_many = 1'b0;
   logic        temp_en = 1'b0;
   logic [15:0] div_int = '0;
   logic [7:0]  div_frac = '0;
   logic        fifo_en = 1'b1;
   logic        dreq_en = 1'b0;
   logic [2:0]  fifo_thresh = 3'd1;
   logic        fifo_shift = 1'b0;
   logic        ovf_clr = 1'b0;
   logic        fifo_rd = 1'b0;
   logic [59:0] ain = {12'hDEF, 12'hABC, 12'h789, 12'h456, 12'h123};
   logic        ready;
   logic [11:0] fifo_data;
   logic [2:0]  fifo_level;
   logic        fifo_empty;
   logic        fifo_ovf;
   logic        dreq;

   adc_rr_sequencer #(.CONV_LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .start_chan(start_chan), .rr_mask(rr_mask),
      .start_once(start_once), .start_many(start_many), .temp_en(temp_en),
      .div_int(div_int), .div_frac(div_frac), .fifo_en(fifo_en),
      .dreq_en(dreq_en), .fifo_thresh(fifo_thresh), .fifo_shift(fifo_shift),
      .ovf_clr(ovf_clr), .fifo_rd(fifo_rd), .ain(ain), .ready(ready),
      .fifo_data(fifo_data), .fifo_level(fifo_level), .fifo_empty(fifo_empty),
      .fifo_ovf(fifo_ovf), .dreq(dreq)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rcv = 0;
   bit mon_en = 1'b0;
   string cur_req = "R1";
   logic [11:0] expq [$];
   int times [$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] chval(input int c);
      return ain[c*12 +: 12];
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_en && !fifo_empty) begin
         if (expq.size() == 0) begin
            check(1'b0, cur_req, int'(fifo_data), 0);
         end else begin
            logic [11:0] e;
            e = expq.pop_front();
            check(fifo_data == e, cur_req, int'(fifo_data), int'(e));
         end
         times.push_back(cyc);
         rcv++;
         fifo_rd = 1'b1;
      end else begin
         fifo_rd = 1'b0;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic once(input int ch);
      @(negedge clk);
      start_chan = 3'(ch);
      start_once = 1'b1;
      @(negedge clk);
      start_once = 1'b0;
   endtask

   task automatic wait_rcv(input int n);
      while (rcv < n) @(negedge clk);
   endtask

   // free-running run: expected channels already queued, n samples
   task automatic run_many(input int ch, input logic [4:0] m, input int n);
      rcv = 0;
      times.delete();
      @(negedge clk);
      start_chan = 3'(ch);
      rr_mask = m;
      start_many = 1'b1;
      wait_rcv(n);
      start_many = 1'b0;
      idle(300);
      check(rcv == n, "R13", rcv, n);
      check(expq.size() == 0, cur_req, expq.size(), 0);
   endtask

   initial begin
      fork
         begin
            repeat (150000) @(posedge clk);
            check(1'b0, "watchdog", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      join_none

      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(ready == 1'b1, "R1", ready, 1);
      check(fifo_empty == 1'b1, "R1", fifo_empty, 1);
      check(fifo_level == 3'd0, "R1", fifo_level, 0);
      check(dreq == 1'b0, "R1", dreq, 0);
      check(fifo_ovf == 1'b0, "R1", fifo_ovf, 0);

      // R2 single conversion
      cur_req = "R2";
      mon_en = 1'b1;
      rcv = 0;
      expq.push_back(chval(2));
      once(2);
      check(ready == 1'b0, "R2", ready, 0);
      idle(LAT + 4);
      check(ready == 1'b1, "R2", ready, 1);
      check(rcv == 1, "R2", rcv, 1);

      // R3 rotation with wrap
      cur_req = "R3";
      begin
         int seq [7] = '{1, 3, 0, 1, 3, 0, 1};
         foreach (seq[i]) expq.push_back(chval(seq[i]));
      end
      run_many(1, 5'b01011, 7);
      // R3 rising edge resets pointer to start channel
      expq.push_back(chval(1));
      expq.push_back(chval(3));
      run_many(1, 5'b01011, 2);
      // R3 start channel outside mask, sensor enabled
      temp_en = 1'b1;
      begin
         int seq [5] = '{0, 2, 4, 2, 4};
         foreach (seq[i]) expq.push_back(chval(seq[i]));
      end
      run_many(0, 5'b10100, 5);

      // R5 sensor disabled: slot for channel 4 skipped
      cur_req = "R5";
      temp_en = 1'b0;
      for (int i = 0; i < 3; i++) expq.push_back(chval(2));
      run_many(2, 5'b10100, 3);
      rcv = 0;
      once(4);
      check(ready == 1'b1, "R5", ready, 1);
      idle(LAT + 4);
      check(rcv == 0, "R5", rcv, 0);

      // R4 and R6 zero mask, divider zero
      cur_req = "R4";
      for (int i = 0; i < 9; i++) expq.push_back(chval(3));
      run_many(3, 5'b00000, 9);
      check(times[8] - times[0] == 8 * 96, "R6", times[8] - times[0], 8 * 96);

      // R7 fractional divider
      cur_req = "R7";
      div_int = 16'd100;
      div_frac = 8'd64;
      for (int i = 0; i < 9; i++) expq.push_back(chval(0));
      run_many(0, 5'b00000, 9);
      check(times[8] - times[0] == 810, "R7", times[8] - times[0], 810);
      div_int = 16'd50;
      div_frac = 8'd0;
      for (int i = 0; i < 9; i++) expq.push_back(chval(0));
      run_many(0, 5'b00000, 9);
      check(times[8] - times[0] == 776, "R7", times[8] - times[0], 776);
      div_int = 16'd0;

      // R8 shift
      cur_req = "R8";
      fifo_shift = 1'b1;
      rcv = 0;
      expq.push_back(12'h045);
      once(1);
      idle(LAT + 4);
      check(rcv == 1, "R8", rcv, 1);
      fifo_shift = 1'b0;

      // R9, R10, R11 with monitor off
      mon_en = 1'b0;
      @(negedge clk);
      dreq_en = 1'b1;
      fifo_thresh = 3'd2;
      once(0); idle(LAT + 3);
      check(fifo_level == 3'd1, "R10", fifo_level, 1);
      check(dreq == 1'b0, "R9", dreq, 0);
      once(1); idle(LAT + 3);
      check(dreq == 1'b1, "R9", dreq, 1);
      dreq_en = 1'b0;
      #1;
      check(dreq == 1'b0, "R9", dreq, 0);
      once(2); idle(LAT + 3);
      once(3); idle(LAT + 3);
      check(fifo_level == 3'd4, "R10", fifo_level, 4);
      check(fifo_ovf == 1'b0, "R11", fifo_ovf, 0);
      once(0); idle(LAT + 3);
      check(fifo_level == 3'd4, "R11", fifo_level, 4);
      check(fifo_ovf == 1'b1, "R11", fifo_ovf, 1);
      idle(5);
      check(fifo_ovf == 1'b1, "R11", fifo_ovf, 1);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      check(fifo_ovf == 1'b0, "R11", fifo_ovf, 0);
      cur_req = "R10";
      for (int i = 0; i < 4; i++) expq.push_back(chval(i));
      rcv = 0;
      mon_en = 1'b1;
      wait_rcv(4);
      idle(3);
      check(fifo_empty == 1'b1, "R10", fifo_empty, 1);
      check(expq.size() == 0, "R10", expq.size(), 0);

      // R12 filling disabled
      cur_req = "R12";
      fifo_en = 1'b0;
      rcv = 0;
      once(2);
      idle(LAT + 4);
      check(fifo_level == 3'd0, "R12", fifo_level, 0);
      check(rcv == 0, "R12", rcv, 0);
      fifo_en = 1'b1;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule